// File: doc/BRIEF.md
# Card Configuration Register Set

This block holds the small group of configuration registers that a removable storage card exposes in its attribute space. The host selects attribute space, then reads and writes single bytes at four even offsets above a base address. It uses these registers to choose the I/O decoding map through a configuration index, to hold the card in soft reset, to read the pending-interrupt and ready state, and to set which drive number the card answers to.

The internal ready line and the raw interrupt request come in from the rest of the card, as does the interrupt-enable bit of the device control register. When the card runs in the direct disk-interface mode the register set is shut off: writes are dropped and reads return zero. Read data is registered and appears on the cycle after the read strobe.

Top module: `card_cfg_regs`

## Requirements
- R1: After reset `cfg_index`, `soft_rst`, `pwr_down` and `drive_id` are 0. With `ready_raw` low the pin register (offset 4) reads 0x0C and the status register (offset 2) reads 0x00.
- R2: An access takes effect only when `acc_reg` is high and `acc_addr` is even and equals BASE+0, +2, +4 or +6 (BASE = 0x200). Odd or other addresses change no state, and a read of them returns 0x00.
- R3: A write to the option register (offset 0) loads bits 5:0 into the configuration index, which drives `cfg_index` from the next cycle. Index 0 selects the memory-mapped map. Option readback shows the index in bits 5:0 and the soft-reset flag in bit 7, with bit 6 reading 0.
- R4: Option bit 7 is the soft-reset flag. `soft_rst` is high while the flag is set and goes low only after the host writes 0 to the flag.
- R5: Status bit 1 reads as `int_req AND irq_en`, sampled in the read cycle. It reads 0 while `irq_en` is low.
- R6: Status bit 2 is a power-down flag that the host can write and read back, and it drives `pwr_down`. The other status bits read 0.
- R7: In the pin register, bit 0 reads the current `ready_raw` and bits 3:2 read 1. Bit 5 is a changed flag. It becomes 1 on the clock edge after `ready_raw` differs from its value at the previous edge.
- R8: A host write to the pin register changes bit 5 only when bit 1 of the same write is 1, and then loads bit 5 of the write data. A ready change in the same cycle wins over the write, so the flag ends at 1.
- R9: Socket register (offset 6) bit 4 selects the drive number on `drive_id`, and bits 3:0 hold a socket number. Both read back, and bits 7:5 read 0.
- R10: While `ide_mode` is high, writes are ignored and reads return 0x00.
- R11: `rd_data` carries the selected register one cycle after a cycle with `acc_rd` high. In every other cycle it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ide_mode | input | 1 | Direct disk-interface mode, disables the register set |
| acc_reg | input | 1 | Attribute space selected (high = attribute access) |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_rd | input | 1 | Read strobe, one cycle |
| acc_addr | input | 11 | Byte address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| int_req | input | 1 | Internal interrupt request pending |
| irq_en | input | 1 | Interrupt enable from device control |
| ready_raw | input | 1 | Internal ready (1) / busy (0) |
| cfg_index | output | 6 | Configuration index, selects I/O map |
| soft_rst | output | 1 | Card soft reset |
| pwr_down | output | 1 | Power-down request |
| drive_id | output | 1 | Drive number the card answers as |

## Verification
The bench targets the masked write to the ready-changed flag. A design that ignored the mask would clear the flag on an unmasked write. It also drives a ready edge in the same cycle as a clearing write, where a design with the wrong priority would lose the change. Interrupt reads are taken with the enable low, where a design that skipped the gating would report a pending request. Odd addresses, attribute-select low and the direct disk-interface mode are each hit with writes, where a loose decoder would corrupt the index or the drive number. The soft-reset flag is checked to stay set across writes to other registers.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int DATA_W = 8;
  localparam int SPAN   = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OPT,
    SEL_STS,
    SEL_PIN,
    SEL_SCK
  } sel_e;

  // Fixed field positions inside the byte-wide registers
  localparam int OPT_SRST_BIT = 7;
  localparam int STS_PWD_BIT  = 2;
  localparam int STS_INT_BIT  = 1;
  localparam int PIN_CHG_BIT  = 5;
  localparam int PIN_MSK_BIT  = 1;
  localparam int PIN_RDY_BIT  = 0;
  localparam int SCK_DRV_BIT  = 4;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] BASE = 11'h200
) (
  input  logic              acc_reg,
  input  logic              ide_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  output sel_e              sel
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(SPAN);

  logic [ADDR_W-1:0] offs;

  always_comb begin
    offs = acc_addr - BASE;
    sel  = SEL_NONE;
    if (acc_reg && !ide_mode && !acc_addr[0] && acc_addr >= BASE && offs < LIMIT) begin
      case (offs[2:1])
        2'd0:    sel = SEL_OPT;
        2'd1:    sel = SEL_STS;
        2'd2:    sel = SEL_PIN;
        default: sel = SEL_SCK;
      endcase
    end
  end
endmodule

// File: rtl/cfg_rdy_track.sv
module cfg_rdy_track (
  input  logic clk,
  input  logic rst,
  input  logic ready_raw,
  input  logic host_wr,
  input  logic host_mask,
  input  logic host_val,
  output logic chg
);
  logic ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= ready_raw;
      chg     <= 1'b0;
    end else begin
      ready_q <= ready_raw;
      if (ready_raw != ready_q)
        chg <= 1'b1;
      else if (host_wr && host_mask)
        chg <= host_val;
    end
  end
endmodule

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
  import cfg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IDX_W  = 6,
  parameter int SOCK_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 11'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ide_mode,
  input  logic              acc_reg,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              int_req,
  input  logic              irq_en,
  input  logic              ready_raw,
  output logic [IDX_W-1:0]  cfg_index,
  output logic              soft_rst,
  output logic              pwr_down,
  output logic              drive_id
);
  sel_e              sel;
  logic              wr_pin;
  logic              chg;
  logic [SOCK_W-1:0] sock_num;
  logic [DATA_W-1:0] rd_next;

  cfg_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .acc_reg  (acc_reg),
    .ide_mode (ide_mode),
    .acc_addr (acc_addr),
    .sel      (sel)
  );

  assign wr_pin = acc_wr && (sel == SEL_PIN);

  cfg_rdy_track u_trk (
    .clk       (clk),
    .rst       (rst),
    .ready_raw (ready_raw),
    .host_wr   (wr_pin),
    .host_mask (acc_wdata[PIN_MSK_BIT]),
    .host_val  (acc_wdata[PIN_CHG_BIT]),
    .chg       (chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_index <= '0;
      soft_rst  <= 1'b0;
      pwr_down  <= 1'b0;
      drive_id  <= 1'b0;
      sock_num  <= '0;
    end else if (acc_wr) begin
      case (sel)
        SEL_OPT: begin
          cfg_index <= acc_wdata[IDX_W-1:0];
          soft_rst  <= acc_wdata[OPT_SRST_BIT];
        end
        SEL_STS: pwr_down <= acc_wdata[STS_PWD_BIT];
        SEL_SCK: begin
          drive_id <= acc_wdata[SCK_DRV_BIT];
          sock_num <= acc_wdata[SOCK_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_OPT: begin
        rd_next[IDX_W-1:0]   = cfg_index;
        rd_next[OPT_SRST_BIT] = soft_rst;
      end
      SEL_STS: begin
        rd_next[STS_PWD_BIT] = pwr_down;
        rd_next[STS_INT_BIT] = int_req && irq_en;
      end
      SEL_PIN: begin
        rd_next[PIN_CHG_BIT] = chg;
        rd_next[3:2]         = 2'b11;
        rd_next[PIN_RDY_BIT] = ready_raw;
      end
      SEL_SCK: begin
        rd_next[SOCK_W-1:0]  = sock_num;
        rd_next[SCK_DRV_BIT] = drive_id;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= acc_rd ? rd_next : '0;
  end
endmodule

// File: rtl/card_cfg_regs_chk.sv
module card_cfg_regs_chk #(
  parameter int ADDR_W = 11,
  parameter int IDX_W  = 6,
  parameter logic [ADDR_W-1:0] BASE = 11'h200
) (
  input logic              clk,
  input logic              rst,
  input logic              ide_mode,
  input logic              acc_reg,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic [7:0]        rd_data,
  input logic              int_req,
  input logic              irq_en,
  input logic              ready_raw,
  input logic [IDX_W-1:0]  cfg_index,
  input logic              soft_rst,
  input logic              pwr_down,
  input logic              drive_id
);
  assert_idx_write_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_reg && acc_wr && !ide_mode && acc_addr == BASE)
      |=> cfg_index == $past(acc_wdata[IDX_W-1:0]));

  assert_srst_write_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_reg && acc_wr && !ide_mode && acc_addr == BASE)
      |=> soft_rst == $past(acc_wdata[7]));

  assert_ide_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ide_mode && acc_wr)
      |=> ($stable(cfg_index) && $stable(soft_rst) && $stable(pwr_down) && $stable(drive_id)));

  assert_odd_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_addr[0])
      |=> ($stable(cfg_index) && $stable(soft_rst) && $stable(pwr_down) && $stable(drive_id)));

  assert_intr_read_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_reg && acc_rd && !ide_mode && acc_addr == BASE + 11'd2)
      |=> rd_data[1] == $past(int_req && irq_en));

  assert_ready_read_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_reg && acc_rd && !ide_mode && acc_addr == BASE + 11'd4)
      |=> rd_data[0] == $past(ready_raw));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> rd_data == 8'h00);
endmodule

bind card_cfg_regs card_cfg_regs_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_chk (.*);

// File: tb/sim_card_cfg_regs.sv
module sim_card_cfg_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ide_mode = 1'b0, acc_reg = 1'b0, acc_wr = 1'b0, acc_rd = 1'b0;
  logic [10:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data;
  logic        int_req = 1'b0, irq_en = 1'b0, ready_raw = 1'b0;
  logic [5:0]  cfg_index;
  logic        soft_rst, pwr_down, drive_id;

  int tests = 0;
  int fails = 0;

  // model state
  logic [5:0] m_idx = '0;
  logic       m_srst = 1'b0, m_pwd = 1'b0, m_drv = 1'b0;
  logic [3:0] m_sock = '0;

  always #2 clk = ~clk;

  card_cfg_regs u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic reg_sel, logic [10:0] a, logic [7:0] d);
    @(negedge clk);
    acc_reg = reg_sel; acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; acc_reg = 1'b0;
  endtask

  task automatic rd(logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_reg = 1'b1; acc_addr = a; acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0; acc_reg = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] opt_exp();
    return {m_srst, 1'b0, m_idx};
  endfunction
  function automatic logic [7:0] sck_exp();
    return {3'b000, m_drv, m_sock};
  endfunction
  function automatic logic [7:0] sts_exp(logic ir, logic en);
    return {5'b0, m_pwd, ir & en, 1'b0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 index", {2'b0, cfg_index}, 8'h00);
    chk("R1 outs", {5'b0, soft_rst, pwr_down, drive_id}, 8'h00);
    rd(11'h204, d); chk("R1 pin", d, 8'h0C);
    rd(11'h202, d); chk("R1 status", d, 8'h00);
    chk("R11 idle", rd_data, 8'h00);

    // R3 / R4 option
    wr(1, 11'h200, 8'h85); m_idx = 6'h05; m_srst = 1;
    chk("R3 index", {2'b0, cfg_index}, 8'h05);
    chk("R4 srst set", {7'b0, soft_rst}, 8'h01);
    wr(1, 11'h206, 8'h13); m_drv = 1; m_sock = 4'h3;
    chk("R4 srst held", {7'b0, soft_rst}, 8'h01);
    chk("R9 drive", {7'b0, drive_id}, 8'h01);
    rd(11'h206, d); chk("R9 readback", d, sck_exp());
    wr(1, 11'h200, 8'h05); m_srst = 0;
    chk("R4 srst clear", {7'b0, soft_rst}, 8'h00);
    rd(11'h200, d); chk("R3 readback", d, opt_exp());

    // R2 odd address, off-range, attribute select low
    wr(1, 11'h201, 8'hBF);
    wr(0, 11'h200, 8'hBF);
    wr(1, 11'h208, 8'h10);
    wr(0, 11'h206, 8'h00);
    chk("R2 index kept", {2'b0, cfg_index}, 8'h05);
    chk("R2 drive kept", {7'b0, drive_id}, 8'h01);
    rd(11'h203, d); chk("R2 odd read", d, 8'h00);

    // R10 ide mode
    ide_mode = 1;
    wr(1, 11'h200, 8'h3F);
    wr(1, 11'h206, 8'h00);
    rd(11'h200, d); chk("R10 read zero", d, 8'h00);
    chk("R10 index kept", {2'b0, cfg_index}, 8'h05);
    ide_mode = 0;

    // R5 interrupt gating
    int_req = 1; irq_en = 0;
    rd(11'h202, d); chk("R5 masked", d, sts_exp(1, 0));
    irq_en = 1;
    rd(11'h202, d); chk("R5 pending", d, sts_exp(1, 1));
    // R6 power-down
    wr(1, 11'h202, 8'h04); m_pwd = 1;
    chk("R6 pwr_down", {7'b0, pwr_down}, 8'h01);
    rd(11'h202, d); chk("R6 readback", d, sts_exp(1, 1));

    // R7 ready change
    @(negedge clk); ready_raw = 1;
    rd(11'h204, d); chk("R7 change set", d, 8'h2D);
    // R8 unmasked write leaves flag, masked write clears
    wr(1, 11'h204, 8'h00);
    rd(11'h204, d); chk("R8 unmasked", d, 8'h2D);
    wr(1, 11'h204, 8'h02);
    rd(11'h204, d); chk("R8 masked clear", d, 8'h0D);
    wr(1, 11'h204, 8'h22);
    rd(11'h204, d); chk("R8 masked set", d, 8'h2D);
    wr(1, 11'h204, 8'h02);
    // R8 change in same cycle as clearing write
    @(negedge clk);
    acc_reg = 1; acc_addr = 11'h204; acc_wdata = 8'h02; acc_wr = 1; ready_raw = 0;
    @(negedge clk);
    acc_wr = 0; acc_reg = 0;
    rd(11'h204, d); chk("R8 change wins", d, 8'h2C);

    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [7:0] v;
      int op;
      op = $urandom % 5;
      v = 8'($urandom);
      case (op)
        0: begin wr(1, 11'h200, v); m_idx = v[5:0]; m_srst = v[7]; end
        1: begin wr(1, 11'h206, v); m_drv = v[4]; m_sock = v[3:0]; end
        2: begin rd(11'h200, d); chk("R3 random", d, opt_exp()); end
        3: begin rd(11'h206, d); chk("R9 random", d, sck_exp()); end
        default: begin
          int_req = v[0]; irq_en = v[1];
          rd(11'h202, d); chk("R5 random", d, sts_exp(v[0], v[1]));
        end
      endcase
    end
    chk("R3 final index", {2'b0, cfg_index}, {2'b0, m_idx});
    chk("R4 final srst", {7'b0, soft_rst}, {7'b0, m_srst});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule